// File: doc/BRIEF.md
# Signed Three-Operand Array Cuber

This block forms the exact product of three signed operands in one combinational pass. Each operand is an N-bit two's-complement bus, and the result is a 3N+1 bit two's-complement word. The block does not feed a two-operand product back into a second multiplier. It builds every one-bit term a_i·b_j·c_k in a single matrix and reduces that matrix with a linear chain of carry-save adder rows. A ripple carry-propagate row then resolves the final sum and carry vectors.

Three cases decide the sign of a term: exactly one operand contributes its sign bit, all three do, or the term is positive. A term whose sign-bit count is odd carries negative weight. Such a term enters the matrix inverted, as a NAND-style term. One fixed correction word goes into the matrix as one more operand. It is the sum of the units lost by those inversions, taken modulo 2^(3N+1). With it, the unsigned reduction yields the signed product. The correction is computed from N at elaboration time, and the block is meant to be built with N = 3 or N = 4.

Top module: `cube_array`

## Requirements
- R1: `prod` equals the exact signed product `op_a*op_b*op_c` as a 3N+1 bit two's-complement value, for every input combination at N = 3 and at N = 4.
- R2: When any operand is zero, `prod` is all zeros.
- R3: When `op_a` is +1, `prod` is the sign-extended product `op_b*op_c`. When `op_a` is all ones (-1), `prod` is the negation of that product.
- R4: When no operand is zero, bit 3N of `prod` equals the XOR of the three operand sign bits (bit N-1). Bits 3N and 3N-1 are always equal.
- R5: Three most-negative operands (-2^(N-1) each) give -2^(3N-3). At N = 3 this is 1111000000.
- R6: At N = 3, the operands 3, 3 and -1 give -9, which is 1111110111.
- R7: Any reordering of the three operands gives the same `prod`.
- R8: The correction word is derived from N alone. It is the two's complement, modulo 2^(3N+1), of the summed weights of all negatively weighted terms. No other setting is needed to change the operand width.
- R9: The path is purely combinational. `prod` reflects the current operands with no register stage or latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | N | First signed operand |
| op_b | input | N | Second signed operand |
| op_c | input | N | Third signed operand |
| prod | output | 3N+1 | Signed product, two's complement |

## Verification
The bench runs every operand triple at both supported widths. Most-negative operands, mixed signs and unit operands are therefore covered along with everything else. A wrong correction word would shift every result by a fixed offset, so even the all-zero triple would fail. A term left uninverted, or inverted when it should not be, shows up only for triples whose sign bits select that term, which is why full coverage matters more than spot values. A carry dropped inside a carry-save row, or a wrong final width, breaks the sign-extension relation between the top two bits of the product on large negative results.

// File: rtl/cube_pkg.sv
package cube_pkg;

  // Product width for an operand width n.
  function automatic int unsigned prod_width(int unsigned n);
    return 3 * n + 1;
  endfunction

  // Correction word for the complemented terms (R8).
  //   Each negatively weighted term t*2^w is entered as ~t*2^w, which adds 2^w.
  //   The sum of those 2^w is subtracted back modulo 2^(3n+1).
  //   One-sign-bit groups: three symmetric groups, each 2^(n-1)*(2^(n-1)-1)^2.
  //   All-sign-bit term:   2^(3n-3).
  function automatic int unsigned corr_const(int unsigned n);
    longint unsigned half;
    longint unsigned per_group;
    longint unsigned lost;
    longint unsigned modulus;
    half      = longint'(1) << (n - 1);
    per_group = half * (half - 1) * (half - 1);
    lost      = 3 * per_group + (longint'(1) << (3 * n - 3));
    modulus   = longint'(1) << (3 * n + 1);
    return int'((modulus - (lost % modulus)) % modulus);
  endfunction

endpackage

// File: rtl/cube_ppgen.sv
module cube_ppgen #(
  parameter int unsigned N    = 3,
  parameter int unsigned W    = 3 * N + 1,
  parameter int unsigned ROWS = N * N
) (
  input  logic [N-1:0]            op_a,
  input  logic [N-1:0]            op_b,
  input  logic [N-1:0]            op_c,
  output logic [ROWS-1:0][W-1:0]  rows
);

  localparam int unsigned MSB = N - 1;

  // One row per (j,k) pair holds the terms a_i*b_j*c_k at weight i+j+k.
  // A term with an odd number of sign-bit indices is entered inverted.
  always_comb begin
    rows = '0;
    for (int j = 0; j < N; j++) begin
      for (int k = 0; k < N; k++) begin
        for (int i = 0; i < N; i++) begin
          logic       term;
          logic [1:0] nsign;
          term  = op_a[i] & op_b[j] & op_c[k];
          nsign = 2'(i == MSB) + 2'(j == MSB) + 2'(k == MSB);
          rows[j*N+k][i+j+k] = nsign[0] ? ~term : term;
        end
      end
    end
  end

  // R2: with a zero operand, every entry equals its inversion flag
  always_comb begin
    if (op_a == '0) begin
      // R2
      zero_row_chk: assert ((rows[0] & ~rows[N-1]) == '0)
        else $error("zero operand produced stray uninverted term");
    end
  end

endmodule

// File: rtl/cube_csa_row.sv
module cube_csa_row #(
  parameter int unsigned W = 10
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic [W-1:0] z,
  output logic [W-1:0] s,
  output logic [W-1:0] cy
);

  // W independent full adders; the carry out of the top column is dropped
  // because the product is taken modulo 2^W.
  always_comb begin
    s     = x ^ y ^ z;
    cy    = '0;
    for (int i = 1; i < W; i++) begin
      cy[i] = (x[i-1] & y[i-1]) | (x[i-1] & z[i-1]) | (y[i-1] & z[i-1]);
    end
  end

  // R1: a row keeps the modular sum of its three inputs
  logic [W-1:0] in_sum;
  logic [W-1:0] out_sum;
  always_comb begin
    in_sum  = x + y + z;
    out_sum = s + cy;
    // R1
    csa_sum_chk: assert (in_sum == out_sum)
      else $error("carry-save row lost weight");
  end

endmodule

// File: rtl/cube_cpa.sv
module cube_cpa #(
  parameter int unsigned W = 10
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  output logic [W-1:0] sum
);

  // Ripple carry-propagate row; carry beyond bit W-1 is discarded.
  always_comb begin
    logic carry;
    carry = 1'b0;
    sum   = '0;
    for (int i = 0; i < W; i++) begin
      sum[i] = x[i] ^ y[i] ^ carry;
      carry  = (x[i] & y[i]) | (carry & (x[i] ^ y[i]));
    end
  end

  // R1: the ripple row is an adder modulo 2^W
  logic [W-1:0] ref_sum;
  always_comb begin
    ref_sum = x + y;
    // R1
    cpa_sum_chk: assert (sum == ref_sum)
      else $error("carry-propagate row mismatch");
  end

endmodule

// File: rtl/cube_array.sv
module cube_array #(
  parameter int unsigned N = 3
) (
  input  logic [N-1:0]   op_a,
  input  logic [N-1:0]   op_b,
  input  logic [N-1:0]   op_c,
  output logic [3*N:0]   prod
);

  localparam int unsigned W      = cube_pkg::prod_width(N);
  localparam int unsigned ROWS   = N * N;
  localparam int unsigned OPS    = ROWS + 1;
  localparam int unsigned STAGES = OPS - 2;
  localparam int unsigned CORR   = cube_pkg::corr_const(N);

  logic [ROWS-1:0][W-1:0]   pp_rows;
  logic [OPS-1:0][W-1:0]    ops;
  logic [STAGES-1:0][W-1:0] st_s;
  logic [STAGES-1:0][W-1:0] st_c;

  cube_ppgen #(.N(N), .W(W), .ROWS(ROWS)) i_ppgen (
    .op_a (op_a),
    .op_b (op_b),
    .op_c (op_c),
    .rows (pp_rows)
  );

  // Correction word is the last operand of the array (R8).
  assign ops = {W'(CORR), pp_rows};

  // Linear carry-save array: each row folds one more operand in.
  for (genvar g = 0; g < STAGES; g++) begin : g_row
    if (g == 0) begin : g_first
      cube_csa_row #(.W(W)) i_csa (
        .x  (ops[0]),
        .y  (ops[1]),
        .z  (ops[2]),
        .s  (st_s[g]),
        .cy (st_c[g])
      );
    end else begin : g_next
      cube_csa_row #(.W(W)) i_csa (
        .x  (st_s[g-1]),
        .y  (st_c[g-1]),
        .z  (ops[g+2]),
        .s  (st_s[g]),
        .cy (st_c[g])
      );
    end
  end

  cube_cpa #(.W(W)) i_cpa (
    .x   (st_s[STAGES-1]),
    .y   (st_c[STAGES-1]),
    .sum (prod)
  );

  // ---------------------------------------------------------------- checks
  logic [W-1:0] ext_b;
  logic [W-1:0] ext_c;
  logic [W-1:0] bc;
  logic [W-1:0] neg_bc;

  always_comb begin
    ext_b  = {{(W-N){op_b[N-1]}}, op_b};
    ext_c  = {{(W-N){op_c[N-1]}}, op_c};
    bc     = ext_b * ext_c;
    neg_bc = '0 - bc;

    if (op_a == '0 || op_b == '0 || op_c == '0) begin
      // R2
      zero_result_chk: assert (prod == '0)
        else $error("zero operand gave nonzero product");
    end

    if (op_a == N'(1)) begin
      // R3
      unit_pos_chk: assert (prod == bc)
        else $error("+1 operand mismatch");
    end

    if (op_a == '1) begin
      // R3
      unit_neg_chk: assert (prod == neg_bc)
        else $error("-1 operand mismatch");
    end

    if (op_a != '0 && op_b != '0 && op_c != '0) begin
      // R4
      sign_rule_chk: assert (prod[W-1] == (op_a[N-1] ^ op_b[N-1] ^ op_c[N-1]))
        else $error("product sign disagrees with operand signs");
    end

    // R4
    no_overflow_chk: assert (prod[W-1] == prod[W-2])
      else $error("product exceeds representable range");
  end

endmodule

// File: tb/test_cube_array.sv
module test_cube_array;

  localparam int unsigned N3 = 3;
  localparam int unsigned N4 = 4;
  localparam int unsigned W3 = 3 * N3 + 1;
  localparam int unsigned W4 = 3 * N4 + 1;

  logic clk;
  int   n_vec;
  int   n_bad;
  int   cycles;
  bit   finished;

  logic [N3-1:0] a3, b3, c3;
  logic [W3-1:0] p3;
  logic [N4-1:0] a4, b4, c4;
  logic [W4-1:0] p4;

  cube_array #(.N(N3)) i_cube_array (
    .op_a (a3), .op_b (b3), .op_c (c3), .prod (p3)
  );

  cube_array #(.N(N4)) i_cube_array_w4 (
    .op_a (a4), .op_b (b4), .op_c (c4), .prod (p4)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic int sx3(logic [N3-1:0] v);
    return v[N3-1] ? int'(v) - (1 << N3) : int'(v);
  endfunction

  function automatic int sx4(logic [N4-1:0] v);
    return v[N4-1] ? int'(v) - (1 << N4) : int'(v);
  endfunction

  task automatic check(string req, longint got, longint exp);
    n_vec++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  // Watchdog: a hung run is one failed check.
  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000 && !finished) begin
      finished = 1'b1;
      n_bad++;
      $display("FAIL watchdog: got %0d cycles expected under 150000", cycles);
      summary();
    end
  end

  initial begin
    logic [W3-1:0] e3;
    logic [W4-1:0] e4;
    logic [W3-1:0] held;
    n_vec = 0; n_bad = 0; cycles = 0; finished = 1'b0;
    a3 = '0; b3 = '0; c3 = '0;
    a4 = '0; b4 = '0; c4 = '0;

    // Start state and combinational response (R2, R9)
    @(negedge clk);
    check("R2 all-zero N=3", p3, 0);
    check("R2 all-zero N=4", p4, 0);
    a3 = 3'd5; b3 = 3'd3; c3 = 3'd2;
    #1;
    e3 = W3'(sx3(a3) * sx3(b3) * sx3(c3));
    check("R9 same-cycle response", p3, e3);

    // Named corner values (R5, R6)
    @(posedge clk); #2;
    a3 = 3'd3; b3 = 3'd3; c3 = 3'b111;
    @(negedge clk);
    check("R6 3*3*-1", p3, 10'b1111110111);
    @(posedge clk); #2;
    a3 = 3'b100; b3 = 3'b100; c3 = 3'b100;
    @(negedge clk);
    check("R5 min cubed N=3", p3, 10'b1111000000);
    @(posedge clk); #2;
    a4 = 4'b1000; b4 = 4'b1000; c4 = 4'b1000;
    @(negedge clk);
    check("R5 min cubed N=4", p4, 13'h1E00);

    // Exhaustive N=3 (R1, R2, R3, R4, R8)
    for (int idx = 0; idx < 512; idx++) begin
      @(posedge clk); #2;
      a3 = idx[2:0]; b3 = idx[5:3]; c3 = idx[8:6];
      @(negedge clk);
      e3 = W3'(sx3(a3) * sx3(b3) * sx3(c3));
      if (a3 == 0 || b3 == 0 || c3 == 0)
        check("R2 zero operand N=3", p3, 0);
      else if (sx3(a3) == 1 || sx3(a3) == -1)
        check("R3 unit operand N=3", p3, e3);
      else
        check("R1 N=3 product", p3, e3);
      check("R4 top bits equal", p3[W3-1], p3[W3-2]);
      if (a3 != 0 && b3 != 0 && c3 != 0)
        check("R4 sign rule", p3[W3-1], a3[2] ^ b3[2] ^ c3[2]);
    end

    // Exhaustive N=4 with the same RTL, other width (R1, R8)
    for (int idx = 0; idx < 4096; idx++) begin
      @(posedge clk); #2;
      a4 = idx[3:0]; b4 = idx[7:4]; c4 = idx[11:8];
      @(negedge clk);
      e4 = W4'(sx4(a4) * sx4(b4) * sx4(c4));
      check("R8 N=4 product", p4, e4);
    end

    // Operand order (R7)
    for (int idx = 0; idx < 512; idx += 7) begin
      @(posedge clk); #2;
      a3 = idx[2:0]; b3 = idx[5:3]; c3 = idx[8:6];
      @(negedge clk);
      held = p3;
      @(posedge clk); #2;
      a3 = idx[8:6]; b3 = idx[2:0]; c3 = idx[5:3];
      @(negedge clk);
      check("R7 rotated order", p3, held);
      @(posedge clk); #2;
      a3 = idx[5:3]; b3 = idx[8:6]; c3 = idx[2:0];
      @(negedge clk);
      check("R7 swapped order", p3, held);
    end

    finished = 1'b1;
    summary();
  end

endmodule